// File: doc/BRIEF.md
# Configurable Memory Map Decoder

This block turns the 16-bit address of an 8-bit processor bus into the chip selects of a small system. The lower 48K of the address space goes to RAM and the upper 16K goes to ROM. A 256-byte I/O page can be placed inside that space by three static switch inputs. When the page is hit, it overrides both memory regions and gives each of three peripherals an 8-byte slot: a timer, a serial port and a parallel port.

The 16K ROM window sits in the upper half of a 32K ROM device. For this, the block drives the device's address bit 14 high on every ROM access, so a CPU address such as $DB00 reaches device offset $5B00. RAM gets a write enable and ROM gets an output enable, each qualified by the read/write line.

All decode results are taken into one output register on the rising clock edge. The selects are therefore glitch-free and appear one cycle after the bus inputs they belong to. A bus-valid strobe gates every select. A synchronous active-high reset clears the outputs.

Top module: `mmap_decoder`

## Requirements
- R1: An access to $0000..$BFFF with bus_valid high asserts ram_cs_n (low), unless the address lies in the I/O page.
- R2: An access to $C000..$FFFF with bus_valid high asserts rom_cs_n (low), unless the address lies in the I/O page.
- R3: The I/O page is hit when addr[15:13] equals page_sw[2:0] (page_sw[2] against A15) and addr[12:8] is zero. On a hit, ram_cs_n and rom_cs_n both stay high, in either memory region.
- R4: Inside the I/O page, addr[7:3] = 0 asserts tmr_cs_n, addr[7:3] = 1 asserts ser_cs_n, and addr[7:3] = 2 asserts par_cs_n.
- R5: I/O page offsets $18..$FF assert no select at all.
- R6: At most one of ram_cs_n, rom_cs_n, tmr_cs_n, ser_cs_n and par_cs_n is low in any cycle.
- R7: With bus_valid low, every select, ram_we_n and rom_oe_n are high and rom_a14 is low.
- R8: ram_we_n is low only when RAM is selected and rd_nwr is 0 (write).
- R9: rom_oe_n is low only when ROM is selected and rd_nwr is 1 (read). A ROM write keeps rom_cs_n low and rom_oe_n high.
- R10: rom_a14 is 1 whenever ROM is selected and 0 otherwise, so CPU $DB00 maps to device offset $5B00.
- R11: The outputs show the decode of the inputs sampled at the preceding rising clock edge. A change of page_sw takes effect on the next access, and no earlier state is involved.
- R12: While rst is high at a rising edge, every select and enable goes high and rom_a14 goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | CPU address |
| bus_valid | input | 1 | Address and rd_nwr are stable |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| page_sw | input | 3 | I/O page position, compared with A15..A13 |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| rom_cs_n | output | 1 | ROM chip select, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| tmr_cs_n | output | 1 | Timer select, active low |
| ser_cs_n | output | 1 | Serial port select, active low |
| par_cs_n | output | 1 | Parallel port select, active low |
| rom_a14 | output | 1 | ROM device address bit 14 |

## Verification
The page match and the memory region decode can both claim the same address in one cycle. This happens when the page is switched into the ROM range ($C0xx, $E0xx) or into the RAM range ($00xx, $A0xx). The bench provokes it by sweeping every switch setting against addresses inside and just outside the page, and by changing page_sw between two back-to-back accesses to one address. In every case it expects only the peripheral select on a page hit, and the memory select with its enable and rom_a14 otherwise, one cycle after the inputs.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    // Memory region picked by the address alone, before the I/O page override.
    typedef enum logic {
        RGN_RAM = 1'b0,
        RGN_ROM = 1'b1
    } region_e;

    // Slot order inside the I/O page; a neighbour decodes this order.
    typedef enum logic [1:0] {
        DEV_TMR = 2'd0,
        DEV_SER = 2'd1,
        DEV_PAR = 2'd2
    } io_dev_e;

    localparam int IO_DEV_CNT = 3;

    // Decode result, active high inside the block.
    typedef struct packed {
        logic ram_cs;
        logic ram_we;
        logic rom_cs;
        logic rom_oe;
        logic tmr_cs;
        logic ser_cs;
        logic par_cs;
        logic rom_hi;
    } sel_t;

    function automatic sel_t sel_idle();
        sel_t s;
        s = '0;
        return s;
    endfunction

endpackage

// File: rtl/mmap_page_match.sv
module mmap_page_match #(
    parameter int ADDR_W  = 16,
    parameter int SW_W    = 3,
    parameter int PAGE_AW = 8
) (
    input  logic [ADDR_W-PAGE_AW-1:0] page_addr,
    input  logic [SW_W-1:0]           page_sw,
    output logic                      hit
);
    localparam int HI_W   = ADDR_W - PAGE_AW;
    localparam int FILL_W = HI_W - SW_W;

    logic sw_eq;
    logic fill_zero;

    assign sw_eq     = (page_addr[HI_W-1 -: SW_W] == page_sw);
    assign fill_zero = (page_addr[FILL_W-1:0] == '0);
    assign hit       = sw_eq && fill_zero;

endmodule

// File: rtl/mmap_mem_region.sv
module mmap_mem_region
    import mmap_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] ROM_BASE = 16'hC000
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           rgn
);
    always_comb begin
        if (addr >= ROM_BASE) rgn = RGN_ROM;
        else                  rgn = RGN_RAM;
    end

endmodule

// File: rtl/mmap_io_slots.sv
module mmap_io_slots #(
    parameter int PAGE_AW = 8,
    parameter int SLOT_AW = 3,
    parameter int N_SLOT  = 3
) (
    input  logic [PAGE_AW-SLOT_AW-1:0] slot_idx,
    output logic [N_SLOT-1:0]          dev_hit
);
    localparam int IDX_W = PAGE_AW - SLOT_AW;

    for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
        assign dev_hit[i] = (slot_idx == IDX_W'(i));
    end

endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter int               SW_W     = 3,
    parameter int               PAGE_AW  = 8,
    parameter int               SLOT_AW  = 3,
    parameter logic [ADDR_W-1:0] ROM_BASE = 16'hC000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bus_valid,
    input  logic              rd_nwr,
    input  logic [SW_W-1:0]   page_sw,
    output logic              ram_cs_n,
    output logic              ram_we_n,
    output logic              rom_cs_n,
    output logic              rom_oe_n,
    output logic              tmr_cs_n,
    output logic              ser_cs_n,
    output logic              par_cs_n,
    output logic              rom_a14
);
    localparam int IDX_W = PAGE_AW - SLOT_AW;

    logic                  page_hit;
    region_e               rgn;
    logic [IO_DEV_CNT-1:0] dev_hit;
    sel_t                  sel_d;
    sel_t                  sel_q;

    mmap_page_match #(
        .ADDR_W (ADDR_W),
        .SW_W   (SW_W),
        .PAGE_AW(PAGE_AW)
    ) u_page (
        .page_addr(addr[ADDR_W-1:PAGE_AW]),
        .page_sw  (page_sw),
        .hit      (page_hit)
    );

    mmap_mem_region #(
        .ADDR_W  (ADDR_W),
        .ROM_BASE(ROM_BASE)
    ) u_region (
        .addr(addr),
        .rgn (rgn)
    );

    mmap_io_slots #(
        .PAGE_AW(PAGE_AW),
        .SLOT_AW(SLOT_AW),
        .N_SLOT (IO_DEV_CNT)
    ) u_slots (
        .slot_idx(addr[PAGE_AW-1:SLOT_AW]),
        .dev_hit (dev_hit)
    );

    // Priority: bus strobe, then I/O page, then memory region.
    always_comb begin
        sel_d = sel_idle();
        if (bus_valid) begin
            if (page_hit) begin
                sel_d.tmr_cs = dev_hit[DEV_TMR];
                sel_d.ser_cs = dev_hit[DEV_SER];
                sel_d.par_cs = dev_hit[DEV_PAR];
            end else if (rgn == RGN_ROM) begin
                sel_d.rom_cs = 1'b1;
                sel_d.rom_oe = rd_nwr;
                sel_d.rom_hi = 1'b1;
            end else begin
                sel_d.ram_cs = 1'b1;
                sel_d.ram_we = !rd_nwr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= sel_idle();
        else     sel_q <= sel_d;
    end

    assign ram_cs_n = !sel_q.ram_cs;
    assign ram_we_n = !sel_q.ram_we;
    assign rom_cs_n = !sel_q.rom_cs;
    assign rom_oe_n = !sel_q.rom_oe;
    assign tmr_cs_n = !sel_q.tmr_cs;
    assign ser_cs_n = !sel_q.ser_cs;
    assign par_cs_n = !sel_q.par_cs;
    assign rom_a14  = sel_q.rom_hi;

endmodule

// File: rtl/mmap_decoder_chk.sv
module mmap_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] addr,
    input logic        bus_valid,
    input logic        rd_nwr,
    input logic [2:0]  page_sw,
    input logic        ram_cs_n,
    input logic        ram_we_n,
    input logic        rom_cs_n,
    input logic        rom_oe_n,
    input logic        tmr_cs_n,
    input logic        ser_cs_n,
    input logic        par_cs_n,
    input logic        rom_a14
);
    logic in_page;
    logic all_off;

    assign in_page = (addr[15:8] == {page_sw, 5'b00000});
    assign all_off = ram_cs_n && ram_we_n && rom_cs_n && rom_oe_n &&
                     tmr_cs_n && ser_cs_n && par_cs_n && !rom_a14;

    assert_ram_region_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && addr < 16'hC000 && !in_page) |=> !ram_cs_n);

    assert_rom_region_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && addr >= 16'hC000 && !in_page) |=> (!rom_cs_n && rom_a14));

    assert_page_override_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && in_page) |=> (ram_cs_n && rom_cs_n));

    assert_page_hole_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && in_page && addr[7:0] >= 8'h18) |=> all_off);

    assert_one_select_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!ram_cs_n, !rom_cs_n, !tmr_cs_n, !ser_cs_n, !par_cs_n}));

    assert_strobe_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> all_off);

    assert_ram_write_R8: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> (!ram_cs_n && !$past(rd_nwr)));

    assert_rom_read_R9: assert property (@(posedge clk) disable iff (rst)
        !rom_oe_n |-> (!rom_cs_n && $past(rd_nwr)));

    assert_rom_hi_R10: assert property (@(posedge clk) disable iff (rst)
        rom_a14 |-> !rom_cs_n);

    assert_reset_R12: assert property (@(posedge clk)
        rst |=> all_off);

endmodule

bind mmap_decoder mmap_decoder_chk u_chk (.*);

// File: tb/sim_mmap_decoder.sv
module sim_mmap_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic        bus_valid = 1'b0;
    logic        rd_nwr = 1'b1;
    logic [2:0]  page_sw = 3'b111;
    logic ram_cs_n, ram_we_n, rom_cs_n, rom_oe_n;
    logic tmr_cs_n, ser_cs_n, par_cs_n, rom_a14;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #2.5 clk = ~clk;

    mmap_decoder u0 (
        .clk(clk), .rst(rst), .addr(addr), .bus_valid(bus_valid),
        .rd_nwr(rd_nwr), .page_sw(page_sw),
        .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
        .rom_cs_n(rom_cs_n), .rom_oe_n(rom_oe_n),
        .tmr_cs_n(tmr_cs_n), .ser_cs_n(ser_cs_n), .par_cs_n(par_cs_n),
        .rom_a14(rom_a14)
    );

    // Spec model: {ram_cs_n, ram_we_n, rom_cs_n, rom_oe_n, tmr, ser, par, a14}
    function automatic logic [7:0] model(input logic r, input logic [15:0] a,
                                         input logic bv, input logic rd,
                                         input logic [2:0] sw);
        logic [7:0] o;
        o = 8'b1111_1110;
        if (!r && bv) begin
            if (a[15:13] == sw && a[12:8] == 5'd0) begin
                if (a[7:0] < 8'h08)      o[3] = 1'b0;
                else if (a[7:0] < 8'h10) o[2] = 1'b0;
                else if (a[7:0] < 8'h18) o[1] = 1'b0;
            end else if (a >= 16'hC000) begin
                o[5] = 1'b0;
                o[4] = !rd;
                o[0] = 1'b1;
            end else begin
                o[7] = 1'b0;
                o[6] = rd;
            end
        end
        return o;
    endfunction

    task automatic apply(input logic r, input logic [15:0] a, input logic bv,
                         input logic rd, input logic [2:0] sw, input string tag);
        @(negedge clk);
        rst = r; addr = a; bus_valid = bv; rd_nwr = rd; page_sw = sw;
        q_exp.push_back(model(r, a, bv, rd, sw));
        q_tag.push_back(tag);
    endtask

    // Monitor: each queued item is due after the next rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                logic [7:0] e;
                logic [7:0] g;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                g = {ram_cs_n, ram_we_n, rom_cs_n, rom_oe_n,
                     tmr_cs_n, ser_cs_n, par_cs_n, rom_a14};
                compared++;
                if (g !== e) begin
                    mismatched++;
                    $display("FAIL %s actual=%b expected=%b", t, g, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R12 reset, driven with a live RAM access
        apply(1, 16'h1234, 1, 0, 3'b111, "R12 reset");
        apply(1, 16'hC000, 1, 1, 3'b110, "R12 reset");
        // R1 / R8 RAM
        apply(0, 16'h0000, 1, 1, 3'b111, "R1 ram read 0000");
        apply(0, 16'h7FFF, 1, 0, 3'b111, "R8 ram write 7FFF");
        apply(0, 16'hBFFF, 1, 0, 3'b111, "R1 ram top BFFF");
        // R2 / R9 / R10 ROM with page at E0xx
        apply(0, 16'hC000, 1, 1, 3'b111, "R2 rom base C000");
        apply(0, 16'hDB00, 1, 1, 3'b111, "R10 rom DB00 a14");
        apply(0, 16'hFFFF, 1, 0, 3'b111, "R9 rom write no oe");
        // R4 / R5 I/O slots at E0xx
        apply(0, 16'hE000, 1, 1, 3'b111, "R4 timer E000");
        apply(0, 16'hE008, 1, 0, 3'b111, "R4 serial E008");
        apply(0, 16'hE017, 1, 1, 3'b111, "R4 parallel E017");
        apply(0, 16'hE018, 1, 1, 3'b111, "R5 hole E018");
        apply(0, 16'hE0FF, 1, 0, 3'b111, "R5 hole E0FF");
        apply(0, 16'hE100, 1, 1, 3'b111, "R2 rom past page E100");
        // R11 switch change between back-to-back accesses
        apply(0, 16'hE000, 1, 1, 3'b111, "R11 page at E0");
        apply(0, 16'hE000, 1, 1, 3'b110, "R11 moved page E000 rom");
        apply(0, 16'hC000, 1, 1, 3'b110, "R11 timer C000");
        apply(0, 16'hC00F, 1, 0, 3'b110, "R4 serial C00F");
        // R7 strobe low
        apply(0, 16'hC010, 0, 1, 3'b110, "R7 no strobe io");
        apply(0, 16'hD000, 0, 1, 3'b110, "R7 no strobe rom");
        apply(0, 16'h2000, 0, 0, 3'b110, "R7 no strobe ram");
        // R3 page in RAM region
        apply(0, 16'h0010, 1, 0, 3'b000, "R3 parallel 0010");
        apply(0, 16'h0100, 1, 0, 3'b000, "R3 ram 0100");
        apply(0, 16'hA000, 1, 1, 3'b101, "R3 timer A000");
        apply(0, 16'hA020, 1, 0, 3'b101, "R3 hole A020 ram off");
        // R6 sweep: every switch setting against page edges
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 6; k++) begin
                logic [15:0] a;
                a = {s[2:0], 13'd0};
                case (k)
                    0: a = a + 16'h0003;
                    1: a = a + 16'h000C;
                    2: a = a + 16'h0011;
                    3: a = a + 16'h0080;
                    4: a = a + 16'h0100;
                    default: a = a - 16'h0001;
                endcase
                apply(0, a, 1, k[0], s[2:0], "R6 sweep");
            end
        end
        apply(0, 16'h0000, 0, 1, 3'b111, "R7 idle");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule